// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block is the lookup stage of a two-way set-associative cache. For each set it keeps one predictor bit that names the way expected to hold the next access to that set. On an accepted request the predicted way's tag and line are read in the same cycle. The output word multiplexer is steered by the predictor bit before any tag result exists, and only that one tag is compared. A correct prediction returns the word one cycle after acceptance. A wrong prediction spends one extra cycle comparing the other way's tag. That cycle ends in either a slow hit, which retrains the predictor, or a miss.

After a miss the block holds the request and waits on a one-line refill write port. The refilled line goes to an invalid way when one exists. Otherwise it replaces the way that was not predicted, and the predictor is pointed at it. The requester sees a ready/valid handshake on the request side and a one-cycle response pulse carrying hit, slow and miss flags plus the requested word. After a miss it re-issues the request once ready returns.

Top module: `wp_cache_lookup`

## Requirements
- R1: Reset clears every valid bit and sets every predictor entry to way 0, so the first access to any address after reset misses. Out of reset, `req_ready` is 1 and `resp_valid` is 0.
- R2: When the predicted way is valid and holds the request tag, `resp_valid` and `resp_hit` pulse one cycle after acceptance with `resp_slow` = 0. `req_ready` stays 1 throughout.
- R3: When the predicted way does not match but the other way does, `resp_hit` pulses with `resp_slow` = 1 two cycles after acceptance. `req_ready` is 0 in the cycle between.
- R4: A slow hit rewrites the set's predictor to the way that matched, so an immediate repeat of the same line is a fast hit.
- R5: When neither way matches, `resp_miss` pulses two cycles after acceptance. `req_ready` stays 0 from acceptance until a refill write is taken.
- R6: A refill write (`refill_we` = 1 while waiting) stores `refill_line` and the held tag into the held set. The target is way 0 if way 0 is invalid, else way 1 if way 1 is invalid, else the way that was not predicted. The predictor is set to that way, and `req_ready` returns to 1 in the next cycle.
- R7: The address splits into a byte offset in bits [3:0], a set index in bits [9:4] and a tag in bits [31:10]. The returned word is 32-bit word number addr[3:2] of the 128-bit line, with word 0 in line bits [31:0].
- R8: Whenever `resp_valid` is 1, exactly one of `resp_hit` and `resp_miss` is 1, and `resp_slow` is 1 only together with `resp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request byte address |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response is a hit |
| resp_slow | output | 1 | Hit was found in the second cycle |
| resp_miss | output | 1 | Neither way held the line |
| resp_data | output | 32 | Requested word on a hit |
| refill_we | input | 1 | Write the refill line (taken only while waiting after a miss) |
| refill_line | input | 128 | Line to store for the missed address |

## Verification
The assertions take for granted that `refill_we` is raised only while the block waits after a miss. Raised in any other state it is dropped, and the refill-to-ready property would not hold there. They also rely on the requester re-issuing a missed access rather than expecting the block to replay it. The stimulus follows both rules: it drives a refill only in the cycle after it has seen a miss, and it presents a new request only when `req_ready` is high. It revisits one set with three competing tags so that fast hits, slow hits and both victim choices all occur. It also sweeps every set index with boundary tag values.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
    localparam int ADDR_W     = 32;
    localparam int SETS       = 64;
    localparam int LINE_BYTES = 16;
    localparam int WORD_W     = 32;
    localparam int WAYS       = 2;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef struct packed {
        tag_t              tag;
        idx_t              idx;
        logic [OFF_W-1:0]  off;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FILL  = 2'd2
    } state_e;

    typedef struct packed {
        logic  valid;
        logic  hit;
        logic  slow;
        logic  miss;
        word_t data;
    } resp_t;

    function automatic word_t pick_word(input line_t line, input logic [OFF_W-1:0] off);
        logic [WSEL_W-1:0] ws;
        ws = off[OFF_W-1 -: WSEL_W];
        return line[ws*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/wp_tag_ways.sv
module wp_tag_ways
    import wp_cache_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  idx_t                   rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]        rd_valid,
    input  logic                   wr_en,
    input  way_t                   wr_way,
    input  idx_t                   wr_idx,
    input  tag_t                   wr_tag
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_t            tags [SETS];
        logic [SETS-1:0] vbits;

        always_ff @(posedge clk) begin
            if (rst) begin
                vbits <= '0;
            end else if (wr_en && wr_way == way_t'(w)) begin
                vbits[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == way_t'(w)) begin
                tags[wr_idx] <= wr_tag;
            end
        end

        assign rd_tag[w]   = tags[rd_idx];
        assign rd_valid[w] = vbits[rd_idx];
    end
endmodule

// File: rtl/wp_line_ways.sv
module wp_line_ways
    import wp_cache_pkg::*;
(
    input  logic                        clk,
    input  idx_t                        rd_idx,
    output logic [WAYS-1:0][LINE_W-1:0] rd_line,
    input  logic                        wr_en,
    input  way_t                        wr_way,
    input  idx_t                        wr_idx,
    input  line_t                       wr_line
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        line_t lines [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == way_t'(w)) begin
                lines[wr_idx] <= wr_line;
            end
        end

        assign rd_line[w] = lines[rd_idx];
    end
endmodule

// File: rtl/wp_way_pred.sv
module wp_way_pred
    import wp_cache_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output way_t rd_way,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  way_t wr_way
);
    way_t guess [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) guess[s] <= '0;
        end else if (wr_en) begin
            guess[wr_idx] <= wr_way;
        end
    end

    assign rd_way = guess[rd_idx];
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
    import wp_cache_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [31:0]  req_addr,
    output logic         resp_valid,
    output logic         resp_hit,
    output logic         resp_slow,
    output logic         resp_miss,
    output logic [31:0]  resp_data,
    input  logic         refill_we,
    input  logic [127:0] refill_line
);
    state_e state;
    addr_t  in_a, hold_a;
    way_t   hold_pred;
    resp_t  resp;

    idx_t                        rd_idx;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    way_t                        pred_way;

    way_t  slow_way, victim;
    logic  fast_match, slow_match, accept, fill_go, pred_we;
    word_t fast_word, slow_word;
    way_t  pred_wval;

    assign in_a      = addr_t'(req_addr);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_idx    = (state == ST_IDLE) ? in_a.idx : hold_a.idx;

    // Predicted way only: mux steered before the tag result is known
    assign fast_word  = pick_word(rd_line[pred_way], in_a.off);
    assign fast_match = rd_valid[pred_way] && (rd_tag[pred_way] == in_a.tag);

    assign slow_way   = ~hold_pred;
    assign slow_word  = pick_word(rd_line[slow_way], hold_a.off);
    assign slow_match = rd_valid[slow_way] && (rd_tag[slow_way] == hold_a.tag);

    always_comb begin
        if (!rd_valid[0])      victim = way_t'(0);
        else if (!rd_valid[1]) victim = way_t'(1);
        else                   victim = ~hold_pred;
    end

    assign fill_go = (state == ST_FILL) && refill_we;

    always_comb begin
        pred_we   = 1'b0;
        pred_wval = victim;
        if (state == ST_PROBE && slow_match) begin
            pred_we   = 1'b1;
            pred_wval = slow_way;
        end else if (fill_go) begin
            pred_we   = 1'b1;
        end
    end

    wp_tag_ways u_tags (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .wr_en(fill_go), .wr_way(victim), .wr_idx(hold_a.idx), .wr_tag(hold_a.tag)
    );

    wp_line_ways u_lines (
        .clk(clk), .rd_idx(rd_idx), .rd_line(rd_line),
        .wr_en(fill_go), .wr_way(victim), .wr_idx(hold_a.idx), .wr_line(refill_line)
    );

    wp_way_pred u_pred (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_way(pred_way),
        .wr_en(pred_we), .wr_idx(hold_a.idx), .wr_way(pred_wval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            resp      <= '0;
            hold_a    <= '0;
            hold_pred <= '0;
        end else begin
            resp <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (fast_match) begin
                            resp <= '{valid: 1'b1, hit: 1'b1, slow: 1'b0, miss: 1'b0, data: fast_word};
                        end else begin
                            hold_a    <= in_a;
                            hold_pred <= pred_way;
                            state     <= ST_PROBE;
                        end
                    end
                end
                ST_PROBE: begin
                    if (slow_match) begin
                        resp  <= '{valid: 1'b1, hit: 1'b1, slow: 1'b1, miss: 1'b0, data: slow_word};
                        state <= ST_IDLE;
                    end else begin
                        resp  <= '{valid: 1'b1, hit: 1'b0, slow: 1'b0, miss: 1'b1, data: '0};
                        state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (refill_we) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = resp.valid;
    assign resp_hit   = resp.hit;
    assign resp_slow  = resp.slow;
    assign resp_miss  = resp.miss;
    assign resp_data  = resp.data;
endmodule

// File: rtl/wp_cache_sva.sv
module wp_cache_sva (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_slow,
    input logic resp_miss,
    input logic refill_we
);
    a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_hit ^ resp_miss));

    a_r8_slow_needs_hit: assert property (@(posedge clk) disable iff (rst)
        resp_slow |-> (resp_valid && resp_hit));

    a_r2_fast_from_accept: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit && !resp_slow) |-> $past(req_valid && req_ready));

    a_r3_slow_after_stall: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_slow) |-> $past(!req_ready));

    a_r5_miss_blocks: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_miss) |-> !req_ready);

    a_r6_ready_after_refill: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_miss && refill_we) |=> req_ready);
endmodule

bind wp_cache_lookup wp_cache_sva u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_slow(resp_slow),
    .resp_miss(resp_miss), .refill_we(refill_we)
);

// File: tb/tb_wp_cache_lookup.sv
module tb_wp_cache_lookup;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_addr;
    logic         resp_valid, resp_hit, resp_slow, resp_miss;
    logic [31:0]  resp_data;
    logic         refill_we;
    logic [127:0] refill_line;

    always #2 clk = ~clk;

    wp_cache_lookup dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_slow(resp_slow), .resp_miss(resp_miss), .resp_data(resp_data),
        .refill_we(refill_we), .refill_line(refill_line)
    );

    typedef struct {
        logic        hit;
        logic        slow;
        logic        miss;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    // Reference state built from the requirements
    logic [21:0] m_tag [2][64];
    logic        m_val [2][64];
    logic        m_pred [64];

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [127:0] line_of(input logic [31:0] a);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of({a[31:4], w[1:0], 2'b00});
        return l;
    endfunction

    function automatic logic [31:0] mk(input logic [21:0] t, input logic [5:0] i, input logic [3:0] o);
        return {t, i, o};   // R7 field layout
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (expq.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8 actual=unexpected response expected=none");
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " hit"},  {31'd0, resp_hit},  {31'd0, e.hit});
                check({e.tag, " slow"}, {31'd0, resp_slow}, {31'd0, e.slow});
                check({e.tag, " miss"}, {31'd0, resp_miss}, {31'd0, e.miss});
                if (e.hit) check({e.tag, " data"}, resp_data, e.data);
            end
        end
    end

    task automatic access(input logic [31:0] a);
        logic [5:0]  i;
        logic [21:0] t;
        logic        p, o, v;
        exp_t        e;
        i = a[9:4];
        t = a[31:10];
        p = m_pred[i];
        o = ~p;
        if (m_val[p][i] && m_tag[p][i] == t) begin
            e = '{hit: 1'b1, slow: 1'b0, miss: 1'b0, data: word_of(a), tag: "R2"};
        end else if (m_val[o][i] && m_tag[o][i] == t) begin
            e = '{hit: 1'b1, slow: 1'b1, miss: 1'b0, data: word_of(a), tag: "R3"};
            m_pred[i] = o;   // R4
        end else begin
            e = '{hit: 1'b0, slow: 1'b0, miss: 1'b1, data: 32'd0, tag: "R5"};
            if (!m_val[0][i])      v = 1'b0;   // R6 victim order
            else if (!m_val[1][i]) v = 1'b1;
            else                   v = o;
            m_val[v][i] = 1'b1;
            m_tag[v][i] = t;
            m_pred[i]   = v;
        end
        expq.push_back(e);

        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (e.hit && !e.slow) begin
            check("R2 ready", {31'd0, req_ready}, 32'd1);
        end else begin
            check(e.miss ? "R5 ready" : "R3 ready", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            if (e.miss) begin
                check("R5 ready held", {31'd0, req_ready}, 32'd0);
                refill_we   = 1'b1;
                refill_line = line_of(a);
                @(negedge clk);
                refill_we = 1'b0;
                check("R6 ready", {31'd0, req_ready}, 32'd1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 64; s++) begin
            m_pred[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_val[w][s] = 1'b0;
                m_tag[w][s] = '0;
            end
        end
        rst = 1'b1; req_valid = 1'b0; req_addr = '0;
        refill_we = 1'b0; refill_line = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 resp", {31'd0, resp_valid}, 32'd0);

        // Contended set: fast, slow, victim choices
        access(mk(22'd1, 6'd5, 4'd4));   // R1 miss, fills way 0
        access(mk(22'd1, 6'd5, 4'd8));   // R2 / R7 word 2
        access(mk(22'd2, 6'd5, 4'd0));   // miss, fills invalid way 1
        access(mk(22'd2, 6'd5, 4'd12));  // fast in way 1
        access(mk(22'd1, 6'd5, 4'd0));   // R3 slow hit
        access(mk(22'd1, 6'd5, 4'd4));   // R4 now fast
        access(mk(22'd3, 6'd5, 4'd0));   // R6 evicts non-predicted way 1
        access(mk(22'd1, 6'd5, 4'd12));  // slow hit on way 0
        access(mk(22'd2, 6'd5, 4'd8));   // evicted earlier: miss
        access(mk(22'd3, 6'd5, 4'd4));   // evicted again: miss

        // Sweep all sets with boundary tags
        for (int s = 0; s < 64; s++) access(mk(22'h3FFFFF, s[5:0], 4'd0));
        for (int s = 0; s < 64; s++) access(mk(22'h000000, s[5:0], s[3:0]));
        for (int s = 0; s < 64; s++) access(mk(22'h3FFFFF, s[5:0], {s[1:0], 2'b00}));
        for (int s = 0; s < 64; s++) access(mk(22'h000000, s[5:0], 4'd12));

        repeat (3) @(negedge clk);
        check("R8 drained", expq.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule